// File: doc/BRIEF.md
# Backlight Pulse-Width Generator with Staged Timing Update

This block drives one pulse-width-modulated output for a display backlight. A clock prescaler slows the input clock. A period counter then runs over the slowed ticks, and the output is high while the counter is below a programmed high-time count. Software sets the prescaler, the period and the high time through a small 32-bit register bus. Each register is written or read whole, with no byte lanes.

Timing values written over the bus land in a staged copy first. A commit request moves the staged copy into the working copy that the counters use. A commit made while the output runs takes effect only where one period ends and the next begins, so no period is ever cut short or stretched. A debug setting can defeat the staging. Bus writes then reach the working copy on the following cycle. The bus is plain control access, so it has no valid/ready flow control: a write takes effect in the cycle its strobe is sampled, and read data appears one cycle after the read strobe.

Top module: `bklt_pwm`

## Requirements
- R1: After reset every register reads 0 and `pwm_out` is low.
- R2: The register offsets are 0x00 (enable, bit 0), 0x08 (commit, bit 0), 0x10 (prescale divider in bits 25:16), 0x14 (period in bits 11:0 and high count in bits 28:16) and 0x20 (debug, bits 1:0). Read data is valid on the cycle after `bus_rd` is sampled. A read of any other offset returns 0.
- R3: With divider d, period p and high count h, where 0 < h <= p, the output is high for h*(d+1) clocks and low for (p+1-h)*(d+1) clocks, and this repeats.
- R4: With h = 0 the output stays low. With h >= p+1 the output stays high for as long as it is enabled.
- R5: While the enable bit is 0 the output is low. Clearing the bit forces the output low in the cycle after the write.
- R6: Setting the enable bit restarts the prescaler and the period counter from zero, so the first period is complete and begins with its high phase.
- R7: Writing the divider or timing registers without a commit leaves the waveform unchanged.
- R8: A 0-to-1 change of the commit bit requests a transfer of the staged values. While the output runs, the transfer happens at the next period wrap, so the period in progress finishes with the old values.
- R9: A commit requested while the output is disabled is transferred at once, so the next enable uses the new values.
- R10: When the debug field holds 3, every staged value is copied into the working copy on each cycle, so a timing write changes the output without a commit. Any other debug value keeps the staging.
- R11: Write bits outside the defined fields are dropped and read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| pwm_out | output | 1 | Pulse-width-modulated output |

## Verification
Four timing sets are tried, each measured over whole periods: a plain undivided setting, a divided one with short counts, one where the high phase outlasts the low phase, and the largest divider. Together these separate errors in the prescaler from errors in the period and compare logic. The two degenerate high counts (zero, and at or above the period length) show whether the compare saturates correctly. A long period that is changed mid-high-phase tells three cases apart: a staged write with no commit, a commit (which must wait for the wrap), and the debug bypass (which must act at once).

// File: rtl/bklt_pwm_pkg.sv
package bklt_pwm_pkg;
  // register offsets (bytes)
  localparam int unsigned OFS_ENABLE = 'h00;
  localparam int unsigned OFS_COMMIT = 'h08;
  localparam int unsigned OFS_CFG0   = 'h10;
  localparam int unsigned OFS_CFG1   = 'h14;
  localparam int unsigned OFS_DEBUG  = 'h20;

  // field placement inside the 32-bit words
  localparam int unsigned DIV_LSB = 16;
  localparam int unsigned PER_LSB = 0;
  localparam int unsigned HI_LSB  = 16;

  // debug field width and the code that defeats staging
  localparam int unsigned DBG_W      = 2;
  localparam logic [1:0]  DBG_BYPASS = 2'b11;
endpackage

// File: rtl/bklt_pwm_regs.sv
module bklt_pwm_regs
  import bklt_pwm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIV_W  = 10,
  parameter int unsigned PER_W  = 12,
  parameter int unsigned HI_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [DIV_W-1:0]  sh_div,
  output logic [PER_W-1:0]  sh_per,
  output logic [HI_W-1:0]   sh_hi,
  output logic              run_en,
  output logic              bypass,
  output logic              commit_req
);
  logic             commit_q;
  logic [DBG_W-1:0] dbg_q;
  logic             hit_en, hit_cm, hit_c0, hit_c1, hit_dbg;
  logic [31:0]      rd_val;

  assign hit_en  = (bus_addr == ADDR_W'(OFS_ENABLE));
  assign hit_cm  = (bus_addr == ADDR_W'(OFS_COMMIT));
  assign hit_c0  = (bus_addr == ADDR_W'(OFS_CFG0));
  assign hit_c1  = (bus_addr == ADDR_W'(OFS_CFG1));
  assign hit_dbg = (bus_addr == ADDR_W'(OFS_DEBUG));

  // request fires only on a 0->1 change of the stored commit bit
  assign commit_req = bus_wr && hit_cm && bus_wdata[0] && !commit_q;
  assign bypass     = (dbg_q == DBG_BYPASS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en   <= 1'b0;
      commit_q <= 1'b0;
      dbg_q    <= '0;
      sh_div   <= '0;
      sh_per   <= '0;
      sh_hi    <= '0;
    end else if (bus_wr) begin
      if (hit_en)  run_en   <= bus_wdata[0];
      if (hit_cm)  commit_q <= bus_wdata[0];
      if (hit_dbg) dbg_q    <= bus_wdata[DBG_W-1:0];
      if (hit_c0)  sh_div   <= bus_wdata[DIV_LSB +: DIV_W];
      if (hit_c1) begin
        sh_per <= bus_wdata[PER_LSB +: PER_W];
        sh_hi  <= bus_wdata[HI_LSB +: HI_W];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit_en)  rd_val[0] = run_en;
    if (hit_cm)  rd_val[0] = commit_q;
    if (hit_dbg) rd_val[DBG_W-1:0] = dbg_q;
    if (hit_c0)  rd_val[DIV_LSB +: DIV_W] = sh_div;
    if (hit_c1) begin
      rd_val[PER_LSB +: PER_W] = sh_per;
      rd_val[HI_LSB +: HI_W]   = sh_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/bklt_pwm_bank.sv
module bklt_pwm_bank #(
  parameter int unsigned DIV_W = 10,
  parameter int unsigned PER_W = 12,
  parameter int unsigned HI_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] sh_div,
  input  logic [PER_W-1:0] sh_per,
  input  logic [HI_W-1:0]  sh_hi,
  input  logic             commit_req,
  input  logic             bypass,
  input  logic             run_en,
  input  logic             wrap,
  output logic [DIV_W-1:0] act_div,
  output logic [PER_W-1:0] act_per,
  output logic [HI_W-1:0]  act_hi
);
  logic pend_q, want, load;

  assign want = pend_q || commit_req;
  // a running waveform only accepts new timing where a period ends
  assign load = bypass || (want && (wrap || !run_en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      act_div <= '0;
      act_per <= '0;
      act_hi  <= '0;
    end else begin
      pend_q <= want && !load;
      if (load) begin
        act_div <= sh_div;
        act_per <= sh_per;
        act_hi  <= sh_hi;
      end
    end
  end
endmodule

// File: rtl/bklt_pwm_core.sv
module bklt_pwm_core #(
  parameter int unsigned DIV_W = 10,
  parameter int unsigned PER_W = 12,
  parameter int unsigned HI_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [DIV_W-1:0] act_div,
  input  logic [PER_W-1:0] act_per,
  input  logic [HI_W-1:0]  act_hi,
  output logic             wrap,
  output logic             pwm_out
);
  localparam int unsigned CW = (HI_W > PER_W) ? HI_W : PER_W;

  logic [DIV_W-1:0] pre_q;
  logic [PER_W-1:0] cnt_q;
  logic             tick;
  logic [CW-1:0]    cnt_x, hi_x;

  // >= rather than == so a bypass write that shrinks a limit still wraps
  assign tick = (pre_q >= act_div);
  assign wrap = run_en && tick && (cnt_q >= act_per);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!run_en) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  generate
    if (HI_W >= PER_W) begin : g_hi_wide
      assign cnt_x = CW'(cnt_q);
      assign hi_x  = act_hi;
    end else begin : g_per_wide
      assign cnt_x = cnt_q;
      assign hi_x  = CW'(act_hi);
    end
  endgenerate

  assign pwm_out = run_en && (cnt_x < hi_x);
endmodule

// File: rtl/bklt_pwm.sv
module bklt_pwm #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIV_W  = 10,
  parameter int unsigned PER_W  = 12,
  parameter int unsigned HI_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_out
);
  logic [DIV_W-1:0] sh_div, act_div;
  logic [PER_W-1:0] sh_per, act_per;
  logic [HI_W-1:0]  sh_hi, act_hi;
  logic             run_en, bypass, commit_req, wrap;

  bklt_pwm_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sh_div(sh_div), .sh_per(sh_per), .sh_hi(sh_hi),
    .run_en(run_en), .bypass(bypass), .commit_req(commit_req)
  );

  bklt_pwm_bank #(.DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .sh_div(sh_div), .sh_per(sh_per), .sh_hi(sh_hi),
    .commit_req(commit_req), .bypass(bypass), .run_en(run_en), .wrap(wrap),
    .act_div(act_div), .act_per(act_per), .act_hi(act_hi)
  );

  bklt_pwm_core #(.DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) core_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .act_div(act_div), .act_per(act_per), .act_hi(act_hi),
    .wrap(wrap), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/bklt_pwm_chk.sv
module bklt_pwm_chk #(
  parameter int unsigned DIV_W = 10,
  parameter int unsigned PER_W = 12,
  parameter int unsigned HI_W  = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             bypass,
  input logic             wrap,
  input logic             pwm_out,
  input logic [DIV_W-1:0] sh_div,
  input logic [PER_W-1:0] sh_per,
  input logic [HI_W-1:0]  sh_hi,
  input logic [DIV_W-1:0] act_div,
  input logic [PER_W-1:0] act_per,
  input logic [HI_W-1:0]  act_hi
);
  localparam int unsigned CW = ((HI_W > PER_W) ? HI_W : PER_W) + 1;

  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !pwm_out);

  p_zero_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_hi == '0) |-> !pwm_out);

  p_full_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && (CW'(act_hi) > CW'(act_per))) |-> pwm_out);

  p_hold_midperiod_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !bypass && !wrap) |=> ($stable(act_div) && $stable(act_per) && $stable(act_hi)));

  p_restart_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> (pwm_out == (act_hi != '0)));

  p_bypass_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (act_div == $past(sh_div) && act_per == $past(sh_per) && act_hi == $past(sh_hi)));
endmodule

bind bklt_pwm bklt_pwm_chk #(.DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .bypass(bypass), .wrap(wrap),
  .pwm_out(pwm_out), .sh_div(sh_div), .sh_per(sh_per), .sh_hi(sh_hi),
  .act_div(act_div), .act_per(act_per), .act_hi(act_hi)
);

// File: tb/bklt_pwm_tb_top.sv
`timescale 1ns/1ps
module bklt_pwm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int n_chk = 0, n_bad = 0;
  logic [63:0] sb_q[$];
  string cur_tag = "R3";
  bit mon_prev = 1'b0;
  int mon_hi = 0, mon_lo = 0;

  always #2 clk = ~clk;

  bklt_pwm dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    check(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  // driver: stop, stage and commit (applied at once while stopped), arm monitor
  task automatic setup(input int d, input int p, input int h);
    wr(8'h00, 32'h0);
    wr(8'h10, d << 16);
    wr(8'h14, (h << 16) | p);
    wr(8'h08, 32'h1);
    wr(8'h08, 32'h0);
    @(negedge clk);
    sb_q.delete(); mon_prev = 1'b0; mon_hi = 0; mon_lo = 0;
  endtask

  task automatic push(input int d, input int p, input int h, input int n);
    for (int i = 0; i < n; i++) sb_q.push_back({32'(h*(d+1)), 32'((p+1-h)*(d+1))});
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic level_chk(input int cycles, input int exp_ones, input string tag);
    int ones = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); if (pwm_out) ones++;
    end
    check(ones == exp_ones, tag, ones, exp_ones);
  endtask

  // monitor: measures each complete high+low period and compares to the queue
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (pwm_out && !mon_prev) begin
        if (mon_hi > 0 && sb_q.size() > 0) begin
          logic [63:0] e;
          e = sb_q.pop_front();
          check({32'(mon_hi), 32'(mon_lo)} == e, cur_tag, {32'(mon_hi), 32'(mon_lo)}, e);
        end
        mon_hi = 1; mon_lo = 0;
      end else if (pwm_out) mon_hi++;
      else mon_lo++;
      mon_prev = pwm_out;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(pwm_out == 1'b0, "R1 pwm after reset", pwm_out, 0);
    rd_chk(8'h00, 32'h0, "R1 enable");
    rd_chk(8'h08, 32'h0, "R1 commit");
    rd_chk(8'h10, 32'h0, "R1 cfg0");
    rd_chk(8'h14, 32'h0, "R1 cfg1");
    rd_chk(8'h20, 32'h0, "R1 debug");

    // R2 / R11 field placement and truncation
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h03FF_0000, "R11 cfg0 mask");
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk(8'h14, 32'h1FFF_0FFF, "R11 cfg1 mask");
    wr(8'h20, 32'hFFFF_FFFF);
    rd_chk(8'h20, 32'h0000_0003, "R2 debug field");
    wr(8'h20, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk(8'h04, 32'h0, "R2 unmapped");
    rd_chk(8'h18, 32'h0, "R2 unmapped");

    // R3 / R6 / R9 period shapes, each starting from a fresh enable
    cur_tag = "R3 d0 p9 h3";  setup(0, 9, 3);    push(0, 9, 3, 3);
    wr(8'h00, 32'h1); check(pwm_out == 1'b1, "R6 high right after enable", pwm_out, 1); drain();
    cur_tag = "R3 R9 d2 p4 h2"; setup(2, 4, 2);  push(2, 4, 2, 3);  wr(8'h00, 32'h1); drain();
    cur_tag = "R3 d3 p7 h7";  setup(3, 7, 7);    push(3, 7, 7, 2);  wr(8'h00, 32'h1); drain();
    cur_tag = "R3 dmax";      setup(1023, 1, 1); push(1023, 1, 1, 2); wr(8'h00, 32'h1); drain();
    rd_chk(8'h00, 32'h1, "R2 enable readback");

    // R4 degenerate high counts
    setup(1, 3, 4); wr(8'h00, 32'h1); level_chk(20, 20, "R4 high equals period");
    setup(1, 3, 9); wr(8'h00, 32'h1); level_chk(20, 20, "R4 high above period");
    setup(1, 3, 0); wr(8'h00, 32'h1); level_chk(20, 0,  "R4 zero high");

    // R5 disable forces low
    setup(0, 9, 8); wr(8'h00, 32'h1);
    wr(8'h00, 32'h0);
    check(pwm_out == 1'b0, "R5 low after disable", pwm_out, 0);
    level_chk(12, 0, "R5 stays low");

    // R7 staged write without commit, R8 commit waits for the wrap
    cur_tag = "R3 d0 p49 h30"; setup(0, 49, 30); push(0, 49, 30, 1);
    wr(8'h00, 32'h1); drain();
    cur_tag = "R7 no commit"; push(0, 49, 30, 2);
    wr(8'h14, (5 << 16) | 19);
    drain();
    cur_tag = "R8 commit at wrap"; push(0, 49, 30, 1); push(0, 19, 5, 2);
    wr(8'h08, 32'h1); wr(8'h08, 32'h0);
    drain();

    // R10 bypass acts at once; another debug code does not
    wr(8'h20, 32'h3);
    setup(0, 99, 80); wr(8'h00, 32'h1);
    repeat (30) @(negedge clk);
    wr(8'h14, (5 << 16) | 99);
    @(negedge clk);
    check(pwm_out == 1'b0, "R10 bypass write takes effect", pwm_out, 0);
    wr(8'h20, 32'h2);
    setup(0, 99, 80); wr(8'h00, 32'h1);
    repeat (30) @(negedge clk);
    wr(8'h14, (5 << 16) | 99);
    @(negedge clk);
    check(pwm_out == 1'b1, "R10 code 2 keeps staging", pwm_out, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule